// File: doc/BRIEF.md
# Staged Pipeline Control Unit

This block generates the main control strobes for a five-stage in-order pipeline (fetch, decode, execute, memory, write-back) and moves them forward with the instruction they belong to. The opcode field of the instruction word in the decode stage is decoded once. The result is split into three groups: execute, memory and write-back. Each group rides the pipeline registers only as far as the stage that consumes it. Every instruction passes through every stage, and a stage with no work for an instruction sees all-zero strobes.

The destination register number travels with the instruction. At the execute stage the RegDst strobe picks one of the two register fields that were captured in decode. The chosen number is then carried to write-back next to the write enable, so a write always targets the register of the instruction that is retiring. It is never taken from the instruction that currently sits in decode. An invalid decode slot or an active reset injects a bubble whose strobes are all zero. Hazard handling, forwarding, ALU-function decoding and the datapath lie outside this block.

Top module: `stage_ctl_pipe`

## Requirements
- R1: A synchronous active-high reset clears all three pipeline registers at the next rising edge. While reset is high, every output reads zero.
- R2: Opcode bits [31:26] = 000000 (register format) gives RegDst=1, ALUOp=10, ALUSrc=0, Branch=0, MemRead=0, MemWrite=0, RegWrite=1, MemtoReg=0.
- R3: Opcode 100011 (load) gives RegDst=0, ALUOp=00, ALUSrc=1, Branch=0, MemRead=1, MemWrite=0, RegWrite=1, MemtoReg=1.
- R4: Opcode 101011 (store) gives ALUOp=00, ALUSrc=1, MemWrite=1. All other strobes, including the don't-care RegDst and MemtoReg, are 0.
- R5: Opcode 000100 (branch on equal) gives ALUOp=01, Branch=1. All other strobes, including the don't-care RegDst and MemtoReg, are 0.
- R6: Any other opcode with valid high yields all-zero strobes.
- R7: When valid is low, the slot is a bubble. All its strobes are zero, and its write register number reads 0 at write-back.
- R8: A decoded instruction shows its execute group one rising edge after it is presented in decode. Its memory group shows after two edges, and its write-back group after three.
- R9: The write register number shown at write-back is bits [15:11] of that same instruction when its RegDst is 1, and bits [20:16] otherwise. It appears on the same edge as that instruction's write-back group.
- R10: MemRead and MemWrite are never high together, and Branch, MemRead and MemWrite are at most one-hot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| instrWord | input | 32 | Instruction word in the decode stage |
| instrValid | input | 1 | High when instrWord is a real instruction, low for a bubble |
| exRegDst | output | 1 | Execute stage: destination field select |
| exAluOp | output | 2 | Execute stage: ALU operation class |
| exAluSrc | output | 1 | Execute stage: second operand is the immediate |
| memBranch | output | 1 | Memory stage: branch-on-equal |
| memRead | output | 1 | Memory stage: data read |
| memWrite | output | 1 | Memory stage: data write |
| wbRegWrite | output | 1 | Write-back stage: register file write enable |
| wbMemToReg | output | 1 | Write-back stage: write data comes from memory |
| wbRegNum | output | 5 | Write-back stage: destination register number |

## Verification
A corrupted pipeline register shows up at the ports within one to three edges as a strobe in the wrong stage. It looks like a write enable that belongs to a neighbouring instruction, or a register number taken from the younger instruction. The bench sends every opcode with valid both high and low, back to back. Each cycle it compares all three stages against a shift model, so any lag, lead or field mix-up between stages is caught on the edge where it first appears. A reset pulse in mid-stream checks that in-flight writes are cancelled on the next edge.

// File: rtl/stage_ctl_pkg.sv
package stage_ctl_pkg;

  localparam int OPC_W = 6;

  localparam logic [OPC_W-1:0] OPC_RFMT  = 6'b000000;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'b100011;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'b101011;
  localparam logic [OPC_W-1:0] OPC_BEQ   = 6'b000100;

  typedef struct packed {
    logic       regDst;
    logic [1:0] aluOp;
    logic       aluSrc;
  } exCtl_t;

  typedef struct packed {
    logic branch;
    logic memRead;
    logic memWrite;
  } memCtl_t;

  typedef struct packed {
    logic regWrite;
    logic memToReg;
  } wbCtl_t;

  typedef struct packed {
    exCtl_t  ex;
    memCtl_t mem;
    wbCtl_t  wb;
  } ctlBundle_t;

endpackage

// File: rtl/stage_ctl_decoder.sv
module stage_ctl_decoder
  import stage_ctl_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  input  logic             slotValid,
  output ctlBundle_t       ctl
);

  ctlBundle_t rawCtl;

  always_comb begin
    rawCtl = '0;
    unique case (opcode)
      OPC_RFMT: begin
        rawCtl.ex.regDst   = 1'b1;
        rawCtl.ex.aluOp    = 2'b10;
        rawCtl.wb.regWrite = 1'b1;
      end
      OPC_LOAD: begin
        rawCtl.ex.aluSrc   = 1'b1;
        rawCtl.mem.memRead = 1'b1;
        rawCtl.wb.regWrite = 1'b1;
        rawCtl.wb.memToReg = 1'b1;
      end
      OPC_STORE: begin
        rawCtl.ex.aluSrc    = 1'b1;
        rawCtl.mem.memWrite = 1'b1;
      end
      OPC_BEQ: begin
        rawCtl.ex.aluOp    = 2'b01;
        rawCtl.mem.branch  = 1'b1;
      end
      default: rawCtl = '0;
    endcase
  end

  // a bubble carries no strobe at all
  assign ctl = slotValid ? rawCtl : '0;

endmodule

// File: rtl/stage_ctl_regs.sv
module stage_ctl_regs
  import stage_ctl_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  ctlBundle_t       idCtl,
  input  logic [REG_W-1:0] idRt,
  input  logic [REG_W-1:0] idRd,
  output exCtl_t           exCtl,
  output memCtl_t          memCtl,
  output wbCtl_t           wbCtl,
  output logic [REG_W-1:0] wbReg
);

  typedef struct packed {
    ctlBundle_t       ctl;
    logic [REG_W-1:0] rt;
    logic [REG_W-1:0] rd;
  } idEx_t;

  typedef struct packed {
    memCtl_t          mem;
    wbCtl_t           wb;
    logic [REG_W-1:0] dst;
  } exMem_t;

  typedef struct packed {
    wbCtl_t           wb;
    logic [REG_W-1:0] dst;
  } memWb_t;

  idEx_t  idExQ;
  exMem_t exMemQ;
  memWb_t memWbQ;

  logic [REG_W-1:0] exDst;

  // destination chosen where the execute-stage select is available
  assign exDst = idExQ.ctl.ex.regDst ? idExQ.rd : idExQ.rt;

  always_ff @(posedge clk) begin
    if (rst) begin
      idExQ  <= '0;
      exMemQ <= '0;
      memWbQ <= '0;
    end else begin
      idExQ.ctl  <= idCtl;
      idExQ.rt   <= idRt;
      idExQ.rd   <= idRd;
      exMemQ.mem <= idExQ.ctl.mem;
      exMemQ.wb  <= idExQ.ctl.wb;
      exMemQ.dst <= exDst;
      memWbQ.wb  <= exMemQ.wb;
      memWbQ.dst <= exMemQ.dst;
    end
  end

  assign exCtl  = idExQ.ctl.ex;
  assign memCtl = exMemQ.mem;
  assign wbCtl  = memWbQ.wb;
  assign wbReg  = memWbQ.dst;

endmodule

// File: rtl/stage_ctl_pipe.sv
module stage_ctl_pipe
  import stage_ctl_pkg::*;
#(
  parameter int INSTR_W = 32,
  parameter int REG_W   = 5,
  parameter int RD_LSB  = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic               instrValid,
  output logic               exRegDst,
  output logic [1:0]         exAluOp,
  output logic               exAluSrc,
  output logic               memBranch,
  output logic               memRead,
  output logic               memWrite,
  output logic               wbRegWrite,
  output logic               wbMemToReg,
  output logic [REG_W-1:0]   wbRegNum
);

  localparam int RT_LSB  = RD_LSB + REG_W;
  localparam int OPC_LSB = INSTR_W - OPC_W;

  logic             slotValid;
  ctlBundle_t       idCtl;
  logic [REG_W-1:0] idRt;
  logic [REG_W-1:0] idRd;
  exCtl_t           exCtl;
  memCtl_t          memCtl;
  wbCtl_t           wbCtl;

  assign slotValid = instrValid & ~rst;
  assign idRt = slotValid ? instrWord[RT_LSB +: REG_W] : '0;
  assign idRd = slotValid ? instrWord[RD_LSB +: REG_W] : '0;

  stage_ctl_decoder u_dec (
    .opcode    (instrWord[OPC_LSB +: OPC_W]),
    .slotValid (slotValid),
    .ctl       (idCtl)
  );

  stage_ctl_regs #(.REG_W(REG_W)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .idCtl  (idCtl),
    .idRt   (idRt),
    .idRd   (idRd),
    .exCtl  (exCtl),
    .memCtl (memCtl),
    .wbCtl  (wbCtl),
    .wbReg  (wbRegNum)
  );

  assign exRegDst   = exCtl.regDst;
  assign exAluOp    = exCtl.aluOp;
  assign exAluSrc   = exCtl.aluSrc;
  assign memBranch  = memCtl.branch;
  assign memRead    = memCtl.memRead;
  assign memWrite   = memCtl.memWrite;
  assign wbRegWrite = wbCtl.regWrite;
  assign wbMemToReg = wbCtl.memToReg;

endmodule

// File: rtl/stage_ctl_checker.sv
module stage_ctl_checker #(
  parameter int INSTR_W = 32,
  parameter int REG_W   = 5
) (
  input logic               clk,
  input logic               rst,
  input logic [INSTR_W-1:0] instrWord,
  input logic               instrValid,
  input logic               exRegDst,
  input logic [1:0]         exAluOp,
  input logic               exAluSrc,
  input logic               memBranch,
  input logic               memRead,
  input logic               memWrite,
  input logic               wbRegWrite,
  input logic               wbMemToReg,
  input logic [REG_W-1:0]   wbRegNum
);

  p_bubble_clear_r7: assert property (@(posedge clk) disable iff (rst)
    !instrValid |=> (!exRegDst && exAluOp == 2'b00 && !exAluSrc));

  p_mem_onehot_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({memBranch, memRead, memWrite}));

  p_store_lag_r8: assert property (@(posedge clk) disable iff (rst)
    memWrite |-> $past(exAluSrc && !exRegDst));

  p_branch_lag_r8: assert property (@(posedge clk) disable iff (rst)
    memBranch |-> $past(exAluOp == 2'b01));

  p_wb_from_mem_r3: assert property (@(posedge clk) disable iff (rst)
    wbMemToReg |-> $past(memRead));

  p_wb_origin_r9: assert property (@(posedge clk) disable iff (rst)
    wbRegWrite |-> $past(!memWrite && !memBranch));

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!wbRegWrite && !memWrite && !memRead && !memBranch && wbRegNum == '0));

endmodule

bind stage_ctl_pipe stage_ctl_checker #(.INSTR_W(INSTR_W), .REG_W(REG_W)) u_chk (.*);

// File: tb/tb_stage_ctl_pipe.sv
`timescale 1ns/1ps
module tb_stage_ctl_pipe;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] instrWord;
  logic        instrValid;
  logic        exRegDst;
  logic [1:0]  exAluOp;
  logic        exAluSrc;
  logic        memBranch;
  logic        memRead;
  logic        memWrite;
  logic        wbRegWrite;
  logic        wbMemToReg;
  logic [4:0]  wbRegNum;

  int vecCount  = 0;
  int failCount = 0;

  always #2.5 clk = ~clk;

  stage_ctl_pipe dut (
    .clk(clk), .rst(rst), .instrWord(instrWord), .instrValid(instrValid),
    .exRegDst(exRegDst), .exAluOp(exAluOp), .exAluSrc(exAluSrc),
    .memBranch(memBranch), .memRead(memRead), .memWrite(memWrite),
    .wbRegWrite(wbRegWrite), .wbMemToReg(wbMemToReg), .wbRegNum(wbRegNum)
  );

  // bench shift model: slot 0 = execute, 1 = memory, 2 = write-back
  logic [13:0] mdl [3];
  string       mtag [3];

  function automatic logic [13:0] expectFor(logic [31:0] ins, logic v);
    logic [3:0] ex; logic [2:0] mm; logic [1:0] wb; logic [4:0] dst;
    ex = '0; mm = '0; wb = '0; dst = ins[20:16];
    case (ins[31:26])
      6'b000000: begin ex = 4'b1100; wb = 2'b10; dst = ins[15:11]; end
      6'b100011: begin ex = 4'b0001; mm = 3'b010; wb = 2'b11; end
      6'b101011: begin ex = 4'b0001; mm = 3'b001; end
      6'b000100: begin ex = 4'b0010; mm = 3'b100; end
      default: ;
    endcase
    if (!v) begin ex = '0; mm = '0; wb = '0; dst = '0; end
    return {ex, mm, wb, dst};
  endfunction

  function automatic string tagFor(logic [31:0] ins, logic v);
    if (!v) return "R7";
    case (ins[31:26])
      6'b000000: return "R2";
      6'b100011: return "R3";
      6'b101011: return "R4";
      6'b000100: return "R5";
      default:   return "R6";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vecCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkAll();
    chk({mtag[0], " R8 ex"}, {28'd0, exRegDst, exAluOp, exAluSrc}, {28'd0, mdl[0][13:10]});
    chk({mtag[1], " R8 mem"}, {29'd0, memBranch, memRead, memWrite}, {29'd0, mdl[1][9:7]});
    chk({mtag[2], " R8 wb"}, {30'd0, wbRegWrite, wbMemToReg}, {30'd0, mdl[2][6:5]});
    chk({mtag[2], " R9 reg"}, {27'd0, wbRegNum}, {27'd0, mdl[2][4:0]});
    chk("R10", {31'd0, memRead & memWrite}, 32'd0);
  endtask

  // at a falling edge: check, drive, then advance the model for the next rise
  task automatic step(logic [31:0] ins, logic v, logic r);
    @(negedge clk);
    checkAll();
    instrWord  = ins;
    instrValid = v;
    rst        = r;
    if (r) begin
      for (int k = 0; k < 3; k++) begin mdl[k] = '0; mtag[k] = "R1"; end
    end else begin
      mdl[2] = mdl[1]; mtag[2] = mtag[1];
      mdl[1] = mdl[0]; mtag[1] = mtag[0];
      mdl[0] = expectFor(ins, v); mtag[0] = tagFor(ins, v);
    end
  endtask

  function automatic logic [31:0] mkInstr(int op, int salt);
    logic [4:0] rs, rt, rd;
    rs = 5'((op * 5 + salt) & 31);
    rt = 5'((op * 3 + 5 + salt * 7) & 31);
    rd = 5'((op * 7 + salt * 11 + 1) & 31);
    if (rt == rd) rd = rd ^ 5'd1;
    return {6'(op), rs, rt, rd, 5'(salt), 6'((op + salt) & 63)};
  endfunction

  initial begin
    #(5.0 * 100000);
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

  initial begin
    rst = 1'b1; instrValid = 1'b1; instrWord = mkInstr(0, 3);
    for (int k = 0; k < 3; k++) begin mdl[k] = '0; mtag[k] = "R1"; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkAll(); // R1: zero state while reset is held with a valid input
    // full opcode sweep, valid and bubble, several field patterns
    for (int salt = 0; salt < 3; salt++)
      for (int op = 0; op < 64; op++)
        for (int v = 1; v >= 0; v--)
          step(mkInstr(op, salt + v), 1'(v), 1'b0);
    // dense back-to-back writers with distinct destinations (R9)
    for (int n = 0; n < 16; n++) begin
      step(mkInstr(0, n), 1'b1, 1'b0);
      step(mkInstr(35, n), 1'b1, 1'b0);
      step(mkInstr(43, n), 1'b1, 1'b0);
      step(mkInstr(4, n), 1'b1, 1'b0);
    end
    // reset mid-stream cancels in-flight writers (R1)
    step(mkInstr(0, 9), 1'b1, 1'b0);
    step(mkInstr(35, 9), 1'b1, 1'b0);
    step(mkInstr(0, 4), 1'b1, 1'b1);
    step(mkInstr(35, 2), 1'b1, 1'b0);
    for (int n = 0; n < 4; n++) step(mkInstr(0, n), 1'b0, 1'b0);
    @(negedge clk);
    checkAll();
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

endmodule